// File: doc/BRIEF.md
# Inter-Cluster Value Bus

This block is the datapath that moves operand values between the clusters of a clustered wide-issue core. Each cluster reads only its own register file. When one cluster needs a value that another cluster produced, the producing cluster places the value on one of the shared buses. After the bus latency, every cluster holds the value in a per-bus incoming-value register.

Every cycle the current instruction supplies a slice per cluster. The slice has three parts:
- For each bus, a source field. It chooses what the cluster drives onto that bus: a register read, a function-unit result, or nothing.
- For each bus, a destination field. It names the local register that takes the incoming value, or is null.
- For each function-unit operand, a source selection. It picks the register-file read, a bypass from a function unit of the same cluster, an incoming-value register, or zero.

A bus stays occupied for its whole latency after a transfer begins. A global stall freezes every bus countdown and every incoming-value register. The stall also suppresses the side effects of the frozen instruction.

Top module: `xbus_fabric`

## Requirements
- R1: After reset, every bus reads idle (`bus_busy` low), every incoming-value register holds zero, and `proto_err` and `wb_err` are low.
- R2: The bus-source kind selects the transfer value. Kind 1 takes the register-file value returned on `out_rdata` for the address presented on `out_raddr`, which equals `out_idx`. Kind 2 takes function-unit result number `out_idx` mod NFU of that cluster. Kinds 0 and 3 request nothing.
- R3: A request in cycle c to an idle bus is accepted, and `bus_busy` is high for the following LAT cycles. From cycle c+LAT+1 the bus is idle again, and every cluster's incoming-value register for that bus holds the transferred value.
- R4: A request to a busy bus raises `proto_err` in that cycle. The request is ignored: the transfer in flight keeps its value and its timing.
- R5: When several clusters request the same idle bus in one cycle, the lowest-numbered cluster wins and `proto_err` is raised.
- R6: A set destination field (`in_en`) drives `in_wr_en` with `in_wr_addr` equal to `in_reg` and `in_wr_data` equal to that cluster's incoming-value register for the bus. A clear field produces no write.
- R7: If both buses target the same register of one cluster in one cycle, only the bus-1 write is enabled, so the later-ordered bus wins.
- R8: A destination register that equals an enabled function-unit writeback register of the same cluster in the same cycle raises `wb_err`.
- R9: Operand kind 0 passes `opnd_rf`. Kind 1 passes result `opnd_idx` mod NFU of the same cluster. Kind 2 passes incoming-value register `opnd_idx` mod NBUS. Kind 3 passes zero.
- R10: While `stall` is high, bus countdowns and incoming-value registers hold. New requests are ignored without error, and no incoming write is enabled.
- R11: The buses work independently. Two transfers on different buses can be in flight at once without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Global stall; freezes the instruction |
| out_kind | input | NCLU*NBUS*2 | Per cluster and bus: transfer source kind |
| out_idx | input | NCLU*NBUS*RAW | Register address or function-unit number for the transfer |
| out_raddr | output | NCLU*NBUS*RAW | Bus read-port address to the register file |
| out_rdata | input | NCLU*NBUS*DW | Bus read-port data from the register file |
| fu_res | input | NCLU*NFU*DW | Function-unit results |
| in_en | input | NCLU*NBUS | Destination field valid |
| in_reg | input | NCLU*NBUS*RAW | Destination register |
| fu_wb_en | input | NCLU*NFU | Function-unit writeback valid |
| fu_wb_reg | input | NCLU*NFU*RAW | Function-unit writeback register |
| opnd_kind | input | NCLU*NFU*2*2 | Operand source kind |
| opnd_idx | input | NCLU*NFU*2*SW | Operand bypass or bus number |
| opnd_rf | input | NCLU*NFU*2*DW | Operand register-file read data |
| opnd | output | NCLU*NFU*2*DW | Selected operand |
| bus_busy | output | NBUS | Bus occupied |
| in_wr_en | output | NCLU*NBUS | Bus write-port enable to the register file |
| in_wr_addr | output | NCLU*NBUS*RAW | Bus write-port address |
| in_wr_data | output | NCLU*NBUS*DW | Bus write-port data (incoming-value register) |
| proto_err | output | 1 | Busy-bus or contended request |
| wb_err | output | 1 | Incoming write collides with a writeback |

## Verification
The hardest situation to reach is a stall that lands inside a transfer window while, in the same frozen cycles, other requests and destination writes are presented. In that case the countdown must resume exactly where it stopped, and nothing presented under the stall may leak. Directed sequences place a stall in the middle of a transfer and present a request and a write during it. Randomized traffic with sparse requests, frequent stalls and a narrow register range then produces many more overlaps of busy windows, stalls and register collisions. A bench model of the countdowns and incoming registers checks every cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [1:0] {
    BSRC_NONE = 2'd0,
    BSRC_REG  = 2'd1,
    BSRC_FU   = 2'd2,
    BSRC_RSVD = 2'd3
  } bus_src_e;

  typedef enum logic [1:0] {
    OSRC_RF   = 2'd0,
    OSRC_BYP  = 2'd1,
    OSRC_IVR  = 2'd2,
    OSRC_ZERO = 2'd3
  } opnd_src_e;

  // width of an index over n items, at least one bit
  function automatic int cw(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // wrap an index into a table of n entries
  function automatic int pick(input int idx, input int n);
    return idx % n;
  endfunction

  function automatic logic drives_bus(input logic [1:0] k);
    return (k == BSRC_REG) || (k == BSRC_FU);
  endfunction

endpackage

// File: rtl/xbus_lane.sv
module xbus_lane
  import xbus_pkg::*;
#(
  parameter int NCLU = 4,
  parameter int DW   = 16,
  parameter int LAT  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stall,
  input  logic [NCLU-1:0]          req,
  input  logic [NCLU-1:0][DW-1:0]  val,
  output logic                     busy,
  output logic                     deliver,
  output logic [DW-1:0]            payload,
  output logic                     err_busy,
  output logic                     err_multi
);
  localparam int RW = $clog2(LAT + 1);

  logic [RW-1:0]   rem_q;
  logic [DW-1:0]   payload_q;
  logic [NCLU-1:0] grant;
  logic [DW-1:0]   val_sel;
  logic            accept;
  logic            any_req;

  // lowest-numbered requester wins
  always_comb begin
    grant   = '0;
    val_sel = '0;
    for (int c = 0; c < NCLU; c++) begin
      if (req[c] && (grant == '0)) begin
        grant[c] = 1'b1;
        val_sel  = val[c];
      end
    end
  end

  assign any_req   = |req;
  assign busy      = (rem_q != '0);
  assign accept    = any_req && !busy && !stall;
  assign deliver   = (rem_q == RW'(1)) && !stall;
  assign payload   = payload_q;
  assign err_busy  = any_req && busy && !stall;
  assign err_multi = ($countones(req) > 1) && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q     <= '0;
      payload_q <= '0;
    end else if (accept) begin
      rem_q     <= RW'(LAT);
      payload_q <= val_sel;
    end else if (busy && !stall) begin
      rem_q     <= rem_q - 1'b1;
    end
  end

  // R3: an accepted value occupies the bus from the next cycle
  a_r3_payload_capture: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && (payload_q == $past(val_sel)));

  // R3: the bus frees itself right after delivery
  a_r3_free_after_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> !busy);

  // R5: at most one cluster owns the bus
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10: a stall freezes countdown and payload
  a_r10_lane_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(rem_q) && $stable(payload_q));

endmodule

// File: rtl/xbus_clu.sv
module xbus_clu
  import xbus_pkg::*;
#(
  parameter int NBUS = 2,
  parameter int NFU  = 2,
  parameter int DW   = 16,
  parameter int RAW  = 4,
  parameter int SW   = 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               stall,
  input  logic [NBUS-1:0]                    deliver,
  input  logic [NBUS-1:0][DW-1:0]            payload,
  input  logic [NBUS-1:0]                    in_en,
  input  logic [NBUS-1:0][RAW-1:0]           in_reg,
  input  logic [NFU-1:0]                     fu_wb_en,
  input  logic [NFU-1:0][RAW-1:0]            fu_wb_reg,
  input  logic [NFU-1:0][DW-1:0]             fu_res,
  input  logic [NFU-1:0][1:0][1:0]           opnd_kind,
  input  logic [NFU-1:0][1:0][SW-1:0]        opnd_idx,
  input  logic [NFU-1:0][1:0][DW-1:0]        opnd_rf,
  output logic [NFU-1:0][1:0][DW-1:0]        opnd,
  output logic [NBUS-1:0]                    wr_en,
  output logic [NBUS-1:0][RAW-1:0]           wr_addr,
  output logic [NBUS-1:0][DW-1:0]            wr_data,
  output logic                               wb_err
);
  logic [NBUS-1:0][DW-1:0] ivr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivr_q <= '0;
    end else begin
      for (int b = 0; b < NBUS; b++)
        if (deliver[b]) ivr_q[b] <= payload[b];
    end
  end

  // a later bus to the same register shadows an earlier one
  always_comb begin
    for (int b = 0; b < NBUS; b++) begin
      wr_en[b] = in_en[b] && !stall;
      for (int b2 = b + 1; b2 < NBUS; b2++)
        if (in_en[b2] && (in_reg[b2] == in_reg[b])) wr_en[b] = 1'b0;
    end
  end

  assign wr_addr = in_reg;
  assign wr_data = ivr_q;

  always_comb begin
    wb_err = 1'b0;
    for (int b = 0; b < NBUS; b++)
      for (int f = 0; f < NFU; f++)
        if (!stall && in_en[b] && fu_wb_en[f] && (in_reg[b] == fu_wb_reg[f]))
          wb_err = 1'b1;
  end

  always_comb begin
    for (int f = 0; f < NFU; f++) begin
      for (int k = 0; k < 2; k++) begin
        opnd[f][k] = '0;
        case (opnd_kind[f][k])
          OSRC_RF:  opnd[f][k] = opnd_rf[f][k];
          OSRC_BYP: for (int s = 0; s < NFU; s++)
                      if (pick(int'(opnd_idx[f][k]), NFU) == s) opnd[f][k] = fu_res[s];
          OSRC_IVR: for (int s = 0; s < NBUS; s++)
                      if (pick(int'(opnd_idx[f][k]), NBUS) == s) opnd[f][k] = ivr_q[s];
          default:  opnd[f][k] = '0;
        endcase
      end
    end
  end

  // R10: stall holds every incoming-value register
  a_r10_ivr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ivr_q));

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    // R3: an incoming register changes only on its bus's delivery
    a_r3_ivr_on_delivery: assert property (@(posedge clk) disable iff (!rst_n)
      !deliver[b] |=> $stable(ivr_q[b]));
    for (genvar b2 = b + 1; b2 < NBUS; b2++) begin : g_pair
      // R7: two enabled bus writes never share a register
      a_r7_distinct_targets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[b] && wr_en[b2]) |-> (wr_addr[b] != wr_addr[b2]));
    end
  end

endmodule

// File: rtl/xbus_fabric.sv
module xbus_fabric
  import xbus_pkg::*;
#(
  parameter int NCLU = 4,
  parameter int NBUS = 2,
  parameter int NREG = 16,
  parameter int NFU  = 2,
  parameter int DW   = 16,
  parameter int LAT  = 2,
  localparam int RAW = cw(NREG),
  localparam int SW  = cw((NFU > NBUS) ? NFU : NBUS)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   stall,
  input  logic [NCLU-1:0][NBUS-1:0][1:0]         out_kind,
  input  logic [NCLU-1:0][NBUS-1:0][RAW-1:0]     out_idx,
  output logic [NCLU-1:0][NBUS-1:0][RAW-1:0]     out_raddr,
  input  logic [NCLU-1:0][NBUS-1:0][DW-1:0]      out_rdata,
  input  logic [NCLU-1:0][NFU-1:0][DW-1:0]       fu_res,
  input  logic [NCLU-1:0][NBUS-1:0]              in_en,
  input  logic [NCLU-1:0][NBUS-1:0][RAW-1:0]     in_reg,
  input  logic [NCLU-1:0][NFU-1:0]               fu_wb_en,
  input  logic [NCLU-1:0][NFU-1:0][RAW-1:0]      fu_wb_reg,
  input  logic [NCLU-1:0][NFU-1:0][1:0][1:0]     opnd_kind,
  input  logic [NCLU-1:0][NFU-1:0][1:0][SW-1:0]  opnd_idx,
  input  logic [NCLU-1:0][NFU-1:0][1:0][DW-1:0]  opnd_rf,
  output logic [NCLU-1:0][NFU-1:0][1:0][DW-1:0]  opnd,
  output logic [NBUS-1:0]                        bus_busy,
  output logic [NCLU-1:0][NBUS-1:0]              in_wr_en,
  output logic [NCLU-1:0][NBUS-1:0][RAW-1:0]     in_wr_addr,
  output logic [NCLU-1:0][NBUS-1:0][DW-1:0]      in_wr_data,
  output logic                                   proto_err,
  output logic                                   wb_err
);
  logic [NBUS-1:0][NCLU-1:0]          req_m;
  logic [NBUS-1:0][NCLU-1:0][DW-1:0]  val_m;
  logic [NBUS-1:0]                    dlv;
  logic [NBUS-1:0][DW-1:0]            pay;
  logic [NBUS-1:0]                    e_busy, e_multi;
  logic [NCLU-1:0]                    wbe;

  assign out_raddr = out_idx;

  for (genvar c = 0; c < NCLU; c++) begin : g_src
    for (genvar b = 0; b < NBUS; b++) begin : g_bus
      logic [DW-1:0] src_val;
      always_comb begin
        src_val = '0;
        if (out_kind[c][b] == BSRC_REG) begin
          src_val = out_rdata[c][b];
        end else if (out_kind[c][b] == BSRC_FU) begin
          for (int f = 0; f < NFU; f++)
            if (pick(int'(out_idx[c][b]), NFU) == f) src_val = fu_res[c][f];
        end
      end
      assign req_m[b][c] = drives_bus(out_kind[c][b]);
      assign val_m[b][c] = src_val;
    end
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_lane
    xbus_lane #(.NCLU(NCLU), .DW(DW), .LAT(LAT)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .stall    (stall),
      .req      (req_m[b]),
      .val      (val_m[b]),
      .busy     (bus_busy[b]),
      .deliver  (dlv[b]),
      .payload  (pay[b]),
      .err_busy (e_busy[b]),
      .err_multi(e_multi[b])
    );
  end

  for (genvar c = 0; c < NCLU; c++) begin : g_clu
    xbus_clu #(.NBUS(NBUS), .NFU(NFU), .DW(DW), .RAW(RAW), .SW(SW)) u_clu (
      .clk      (clk),
      .rst_n    (rst_n),
      .stall    (stall),
      .deliver  (dlv),
      .payload  (pay),
      .in_en    (in_en[c]),
      .in_reg   (in_reg[c]),
      .fu_wb_en (fu_wb_en[c]),
      .fu_wb_reg(fu_wb_reg[c]),
      .fu_res   (fu_res[c]),
      .opnd_kind(opnd_kind[c]),
      .opnd_idx (opnd_idx[c]),
      .opnd_rf  (opnd_rf[c]),
      .opnd     (opnd[c]),
      .wr_en    (in_wr_en[c]),
      .wr_addr  (in_wr_addr[c]),
      .wr_data  (in_wr_data[c]),
      .wb_err   (wbe[c])
    );
  end

  assign proto_err = |(e_busy | e_multi);
  assign wb_err    = |wbe;

  // R10: no protocol error is reported for a frozen instruction
  a_r10_no_err_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !proto_err && (in_wr_en == '0));

endmodule

// File: tb/xbus_fabric_bench.sv
`timescale 1ns/1ps
module xbus_fabric_bench;
  localparam int NCLU = 4, NBUS = 2, NREG = 16, NFU = 2, DW = 16, LAT = 2;
  localparam int RAW = 4, SW = 1;

  logic clk = 1'b0, rst_n = 1'b0, stall;
  logic [NCLU-1:0][NBUS-1:0][1:0]         out_kind;
  logic [NCLU-1:0][NBUS-1:0][RAW-1:0]     out_idx, out_raddr, in_reg;
  logic [NCLU-1:0][NBUS-1:0][DW-1:0]      out_rdata, in_wr_data;
  logic [NCLU-1:0][NFU-1:0][DW-1:0]       fu_res;
  logic [NCLU-1:0][NBUS-1:0]              in_en, in_wr_en;
  logic [NCLU-1:0][NBUS-1:0][RAW-1:0]     in_wr_addr;
  logic [NCLU-1:0][NFU-1:0]               fu_wb_en;
  logic [NCLU-1:0][NFU-1:0][RAW-1:0]      fu_wb_reg;
  logic [NCLU-1:0][NFU-1:0][1:0][1:0]     opnd_kind;
  logic [NCLU-1:0][NFU-1:0][1:0][SW-1:0]  opnd_idx;
  logic [NCLU-1:0][NFU-1:0][1:0][DW-1:0]  opnd_rf, opnd;
  logic [NBUS-1:0] bus_busy;
  logic proto_err, wb_err;

  int nchk = 0, nfail = 0;
  int rem_m [NBUS];
  logic [DW-1:0] pay_m [NBUS];
  logic [DW-1:0] ivr_m [NCLU][NBUS];

  xbus_fabric #(.NCLU(NCLU), .NBUS(NBUS), .NREG(NREG), .NFU(NFU), .DW(DW), .LAT(LAT)) u_xbus_fabric (
    .clk(clk), .rst_n(rst_n), .stall(stall), .out_kind(out_kind), .out_idx(out_idx),
    .out_raddr(out_raddr), .out_rdata(out_rdata), .fu_res(fu_res), .in_en(in_en),
    .in_reg(in_reg), .fu_wb_en(fu_wb_en), .fu_wb_reg(fu_wb_reg), .opnd_kind(opnd_kind),
    .opnd_idx(opnd_idx), .opnd_rf(opnd_rf), .opnd(opnd), .bus_busy(bus_busy),
    .in_wr_en(in_wr_en), .in_wr_addr(in_wr_addr), .in_wr_data(in_wr_data),
    .proto_err(proto_err), .wb_err(wb_err));

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] rf_val(input int c, input int b, input int a);
    return DW'(16'h5000 + c * 16'h100 + b * 16'h40 + a * 3);
  endfunction

  // register-file model behind the bus read ports
  always_comb
    for (int c = 0; c < NCLU; c++)
      for (int b = 0; b < NBUS; b++)
        out_rdata[c][b] = rf_val(c, b, int'(out_raddr[c][b]));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    stall = 1'b0; out_kind = '0; out_idx = '0; fu_res = '0; in_en = '0; in_reg = '0;
    fu_wb_en = '0; fu_wb_reg = '0; opnd_kind = '0; opnd_idx = '0; opnd_rf = '0;
  endtask

  function automatic logic [DW-1:0] src_m(input int c, input int b);
    if (out_kind[c][b] == 2'd1) return rf_val(c, b, int'(out_idx[c][b]));
    return fu_res[c][int'(out_idx[c][b]) % NFU];
  endfunction

  task automatic model_check();
    logic perr, wbx, en;
    int nreq;
    perr = 1'b0; wbx = 1'b0;
    for (int b = 0; b < NBUS; b++) begin
      nreq = 0;
      for (int c = 0; c < NCLU; c++)
        if (out_kind[c][b] == 2'd1 || out_kind[c][b] == 2'd2) nreq++;
      if (!stall && nreq > 0 && rem_m[b] != 0) perr = 1'b1;
      if (!stall && nreq > 1) perr = 1'b1;
      chk(bus_busy[b], rem_m[b] != 0, "R3 busy");
    end
    chk(proto_err, perr, "R4 R5 proto_err");
    for (int c = 0; c < NCLU; c++) begin
      for (int b = 0; b < NBUS; b++) begin
        chk(out_raddr[c][b], out_idx[c][b], "R2 raddr");
        en = in_en[c][b] && !stall;
        for (int b2 = b + 1; b2 < NBUS; b2++)
          if (in_en[c][b2] && in_reg[c][b2] == in_reg[c][b]) en = 1'b0;
        chk(in_wr_en[c][b], en, "R6 R7 R10 wr_en");
        if (en) begin
          chk(in_wr_addr[c][b], in_reg[c][b], "R6 addr");
          chk(in_wr_data[c][b], ivr_m[c][b], "R3 R6 data");
        end
        for (int f = 0; f < NFU; f++)
          if (!stall && in_en[c][b] && fu_wb_en[c][f] && in_reg[c][b] == fu_wb_reg[c][f]) wbx = 1'b1;
      end
      for (int f = 0; f < NFU; f++)
        for (int k = 0; k < 2; k++) begin
          logic [DW-1:0] e;
          case (opnd_kind[c][f][k])
            2'd0: e = opnd_rf[c][f][k];
            2'd1: e = fu_res[c][int'(opnd_idx[c][f][k]) % NFU];
            2'd2: e = ivr_m[c][int'(opnd_idx[c][f][k]) % NBUS];
            default: e = '0;
          endcase
          chk(opnd[c][f][k], e, "R9 operand");
        end
    end
    chk(wb_err, wbx, "R8 wb_err");
  endtask

  task automatic model_update();
    if (stall) return;
    for (int b = 0; b < NBUS; b++) begin
      if (rem_m[b] != 0) begin
        if (rem_m[b] == 1)
          for (int c = 0; c < NCLU; c++) ivr_m[c][b] = pay_m[b];
        rem_m[b]--;
      end else begin
        for (int c = NCLU - 1; c >= 0; c--)
          if (out_kind[c][b] == 2'd1 || out_kind[c][b] == 2'd2) begin
            pay_m[b] = src_m(c, b);
            rem_m[b] = LAT;
          end
      end
    end
  endtask

  // inputs are set at a falling edge; step samples, clocks, then clears
  task automatic step();
    #1;
    model_check();
    @(posedge clk);
    model_update();
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [DW-1:0] exp_v;
    void'($urandom(32'd2024));
    clear_in();
    for (int b = 0; b < NBUS; b++) begin
      rem_m[b] = 0; pay_m[b] = '0;
      for (int c = 0; c < NCLU; c++) ivr_m[c][b] = '0;
    end
    repeat (3) @(negedge clk);
    chk(bus_busy, '0, "R1 bus idle");
    chk(proto_err, 0, "R1 proto_err");
    chk(wb_err, 0, "R1 wb_err");
    rst_n = 1'b1;

    // R1: incoming registers read zero after reset
    in_en = '1;
    for (int c = 0; c < NCLU; c++) begin in_reg[c][0] = 4'd1; in_reg[c][1] = 4'd2; end
    #0.5;
    for (int c = 0; c < NCLU; c++)
      for (int b = 0; b < NBUS; b++) chk(in_wr_data[c][b], 0, "R1 ivr zero");
    step();

    // R2 R3: register transfer from cluster 2 on bus 0
    out_kind[2][0] = 2'd1; out_idx[2][0] = 4'd5; exp_v = rf_val(2, 0, 5);
    step();
    for (int i = 0; i < LAT; i++) begin
      chk(bus_busy[0], 1, "R3 busy window");
      if (i == 0) begin
        in_en[1][0] = 1'b0; #0.5; chk(in_wr_en[1][0], 0, "R6 null field");
      end
      step();
    end
    chk(bus_busy[0], 0, "R3 freed");
    in_en[1][0] = 1'b1; in_reg[1][0] = 4'd7;
    #0.5;
    chk(in_wr_en[1][0], 1, "R6 write enable");
    chk(in_wr_addr[1][0], 7, "R6 address");
    chk(in_wr_data[1][0], exp_v, "R2 R3 arrival");
    step();

    // R4: request to a busy bus is rejected
    fu_res[0][1] = 16'hBEEF; out_kind[0][0] = 2'd2; out_idx[0][0] = 4'd1;
    step();
    out_kind[3][0] = 2'd1; out_idx[3][0] = 4'd2;
    #0.5; chk(proto_err, 1, "R4 busy request");
    step();
    repeat (LAT - 1) step();
    chk(bus_busy[0], 0, "R4 no restart");
    in_en[1][0] = 1'b1; #0.5; chk(in_wr_data[1][0], 16'hBEEF, "R4 value kept");
    step();

    // R5: contention on bus 1
    out_kind[1][1] = 2'd1; out_idx[1][1] = 4'd3;
    out_kind[3][1] = 2'd2; fu_res[3][0] = 16'h7777;
    #0.5; chk(proto_err, 1, "R5 contention");
    step();
    repeat (LAT) step();
    in_en[2][1] = 1'b1; #0.5; chk(in_wr_data[2][1], rf_val(1, 1, 3), "R5 lowest wins");
    step();

    // R10: stall in the middle of a transfer
    fu_res[2][0] = 16'h1234; out_kind[2][0] = 2'd2;
    step();
    for (int i = 0; i < 3; i++) begin
      stall = 1'b1; in_en[0][0] = 1'b1; out_kind[1][1] = 2'd1;
      #0.5;
      chk(in_wr_en[0][0], 0, "R10 write held");
      chk(proto_err, 0, "R10 no error");
      step();
      chk(bus_busy[0], 1, "R10 countdown held");
      chk(bus_busy[1], 0, "R10 request ignored");
    end
    repeat (LAT) step();
    chk(bus_busy[0], 0, "R10 resumes");
    in_en[3][0] = 1'b1; #0.5; chk(in_wr_data[3][0], 16'h1234, "R10 value");
    step();

    // R11: both buses in flight together
    out_kind[0][0] = 2'd1; out_idx[0][0] = 4'd9;
    out_kind[3][1] = 2'd1; out_idx[3][1] = 4'd10;
    #0.5; chk(proto_err, 0, "R11 no error");
    step();
    chk(bus_busy, 2'b11, "R11 both busy");
    repeat (LAT) step();
    in_en[2] = 2'b11; in_reg[2][0] = 4'd1; in_reg[2][1] = 4'd2;
    #0.5;
    chk(in_wr_data[2][0], rf_val(0, 0, 9), "R11 bus 0");
    chk(in_wr_data[2][1], rf_val(3, 1, 10), "R11 bus 1");
    step();

    // R7: same register from both buses
    in_en[3] = 2'b11; in_reg[3][0] = 4'd6; in_reg[3][1] = 4'd6;
    #0.5;
    chk(in_wr_en[3][0], 0, "R7 bus 0 dropped");
    chk(in_wr_en[3][1], 1, "R7 bus 1 kept");
    step();

    // R8: collision with a writeback
    in_en[0][1] = 1'b1; in_reg[0][1] = 4'd4; fu_wb_en[0][0] = 1'b1; fu_wb_reg[0][0] = 4'd4;
    #0.5; chk(wb_err, 1, "R8 collision");
    step();
    in_en[0][1] = 1'b1; in_reg[0][1] = 4'd4; fu_wb_en[0][0] = 1'b1; fu_wb_reg[0][0] = 4'd5;
    #0.5; chk(wb_err, 0, "R8 distinct");
    step();

    // R9: operand sources
    opnd_kind[1][0][0] = 2'd0; opnd_rf[1][0][0] = 16'hAAAA;
    opnd_kind[1][0][1] = 2'd1; opnd_idx[1][0][1] = 1'b1; fu_res[1][1] = 16'h5555;
    opnd_kind[1][1][0] = 2'd2; opnd_idx[1][1][0] = 1'b1;
    opnd_kind[1][1][1] = 2'd3; opnd_rf[1][1][1] = 16'hFFFF;
    #0.5;
    chk(opnd[1][0][0], 16'hAAAA, "R9 register read");
    chk(opnd[1][0][1], 16'h5555, "R9 bypass");
    chk(opnd[1][1][0], rf_val(3, 1, 10), "R9 incoming");
    chk(opnd[1][1][1], 0, "R9 zero");
    step();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      stall = ($urandom % 8) == 0;
      for (int c = 0; c < NCLU; c++) begin
        for (int b = 0; b < NBUS; b++) begin
          out_kind[c][b] = (($urandom % 7) == 0) ? 2'($urandom) : 2'd0;
          out_idx[c][b]  = RAW'($urandom);
          in_en[c][b]    = ($urandom % 3) == 0;
          in_reg[c][b]   = RAW'($urandom % 4);
        end
        for (int f = 0; f < NFU; f++) begin
          fu_res[c][f]    = DW'($urandom);
          fu_wb_en[c][f]  = ($urandom % 3) == 0;
          fu_wb_reg[c][f] = RAW'($urandom % 4);
          for (int k = 0; k < 2; k++) begin
            opnd_kind[c][f][k] = 2'($urandom);
            opnd_idx[c][f][k]  = SW'($urandom);
            opnd_rf[c][f][k]   = DW'($urandom);
          end
        end
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule